// File: doc/BRIEF.md
# Configurable Single-Clock FIFO

This block is a first-in first-out buffer in which writes and reads share one clock. Its data width is a free parameter. Its depth is a power of two, at least four. It keeps a running word count. From that count it drives the full, empty and half-full indications, and also two threshold flags whose levels are set by parameters. It fits between two pieces of logic in the same clock domain that produce and consume data at uneven rates.

A read-mode parameter picks one of two behaviours:
- **Fetch mode.** A read request loads the oldest word into an output flop, so the data appears after the request.
- **Look-ahead mode.** The oldest word is already on the output whenever the buffer holds data, and a read request acknowledges and removes it.

In fetch mode, an optional second output flop trades one more cycle of latency for timing slack. Two more parameters control overflow and underflow guarding. With a guard on, an illegal access is dropped. With it off, the access goes through and may corrupt the stored data.

The buffer has two ways to be emptied. A synchronous flush input does it at a clock edge. An asynchronous clear input does it at once.

Top module: `sc_fifo`

## Requirements
- R1: While `aclr` is high, the block shows, without waiting for a clock edge: `count` = 0, `empty` = 1, `full` = 0, `almost_empty` = 1, `almost_full` = 0, `half_full` = 0. In fetch mode, `rd_data` is also 0.
- R2: At each edge, `count` rises by one for an accepted write and falls by one for an accepted read. A simultaneous read and write while the buffer is neither full nor empty leaves `count` unchanged.
- R3: `full` is 1 exactly when `count` equals DEPTH. `empty` is 1 exactly when `count` is 0.
- R4: `almost_full` is 1 whenever `count` >= AF_LEVEL. `almost_empty` is 1 whenever `count` < AE_LEVEL.
- R5: `half_full` is 1 whenever `count` >= DEPTH/2. It is the OR of the two most significant bits of `count`.
- R6: In fetch mode without the extra flop, an accepted read loads the oldest word into `rd_data` at that same edge. Words come out in write order. Without an accepted read, `rd_data` holds its value.
- R7: With OUT_REG = 1 in fetch mode, `rd_data` shows, one cycle later, what it would show with OUT_REG = 0.
- R8: In look-ahead mode, while `empty` is 0, `rd_data` shows the oldest stored word before any request. A read request removes that word at the next edge.
- R9: With overflow guarding on, a write while `full` is 1 is dropped. Both the count and the stored words stay unchanged.
- R10: With underflow guarding on, a read while `empty` is 1 is dropped. `count` stays 0, and in fetch mode `rd_data` holds its value.
- R11: With overflow guarding off, a write while full stores the new word into the slot of the oldest word. In look-ahead mode that new word then appears on `rd_data`. `count` stays at DEPTH.
- R12: With underflow guarding off, a read while empty leaves `count` at 0 and `empty` at 1.
- R13: A high `sclr` at an edge empties the buffer. It takes priority over a write or read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| aclr | input | 1 | Asynchronous clear, active high |
| sclr | input | 1 | Synchronous flush, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request (fetch mode) or acknowledge (look-ahead mode) |
| rd_data | output | DATA_W | Word read out |
| count | output | log2(DEPTH)+1 | Number of stored words |
| full | output | 1 | Count equals DEPTH |
| empty | output | 1 | Count is zero |
| almost_full | output | 1 | Count at or above AF_LEVEL |
| almost_empty | output | 1 | Count below AE_LEVEL |
| half_full | output | 1 | Count at or above DEPTH/2 |

## Verification
The hardest states to reach from the ports are the unguarded ones: a write into a full buffer and a read from an empty one. Random traffic gated by a model never produces them. The bench therefore drives a look-ahead instance with both guards off next to two guarded fetch-mode instances. It fills all three with known words, then forces one extra write on every instance and one extra read on an empty buffer. The overwritten head word and the clamped count are checked against the guarded instances, which must drop the same accesses. After the resulting corruption, a synchronous flush brings the unguarded instance back into step with the model. Biased random phases then drive the count repeatedly to both ends and across both thresholds.

// File: rtl/sc_fifo_pkg.sv
package sc_fifo_pkg;

   typedef enum logic {
      RD_FETCH     = 1'b0,
      RD_LOOKAHEAD = 1'b1
   } rd_mode_e;

   typedef struct packed {
      logic full;
      logic empty;
      logic afull;
      logic aempty;
      logic hfull;
   } lvl_flags_t;

endpackage

// File: rtl/sc_fifo_ctrl.sv
module sc_fifo_ctrl #(
   parameter int DEPTH     = 16,
   parameter bit OVF_GUARD = 1'b1,
   parameter bit UNF_GUARD = 1'b1,
   parameter int AF_LEVEL  = 12,
   parameter int AE_LEVEL  = 3,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic                     clk,
   input  logic                     aclr,
   input  logic                     sclr,
   input  logic                     wr_en,
   input  logic                     rd_en,
   output logic                     wr_ok,
   output logic                     rd_ok,
   output logic [AW-1:0]            wr_ptr,
   output logic [AW-1:0]            rd_ptr,
   output logic [CW-1:0]            count,
   output sc_fifo_pkg::lvl_flags_t  flags
);

   localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
   localparam logic [CW-1:0] AF_CNT  = CW'(AF_LEVEL);
   localparam logic [CW-1:0] AE_CNT  = CW'(AE_LEVEL);

   logic [CW-1:0] cnt_nx;
   logic          is_full;
   logic          is_empty;

   assign is_full  = (count == CNT_MAX);
   assign is_empty = (count == '0);

   // Guards: a disabled guard lets the access through regardless of level.
   assign wr_ok = wr_en && !sclr && !(OVF_GUARD && is_full);
   assign rd_ok = rd_en && !sclr && !(UNF_GUARD && is_empty);

   // Count clamps at both ends so an unguarded access cannot wrap it.
   always_comb begin
      cnt_nx = count;
      if (wr_ok && !rd_ok && !is_full)
         cnt_nx = count + 1'b1;
      else if (rd_ok && !wr_ok && !is_empty)
         cnt_nx = count - 1'b1;
   end

   always_ff @(posedge clk or posedge aclr) begin
      if (aclr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (sclr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
         if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
         count <= cnt_nx;
      end
   end

   always_comb begin
      flags.full   = is_full;
      flags.empty  = is_empty;
      flags.afull  = (count >= AF_CNT);
      flags.aempty = (count < AE_CNT);
      flags.hfull  = count[CW-1] | count[CW-2];
   end

endmodule

// File: rtl/sc_fifo_mem.sv
module sc_fifo_mem #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/sc_fifo_rdport.sv
module sc_fifo_rdport #(
   parameter int DATA_W     = 8,
   parameter bit LOOKAHEAD  = 1'b0,
   parameter bit OUT_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              aclr,
   input  logic              rd_ok,
   input  logic [DATA_W-1:0] head,
   output logic [DATA_W-1:0] rd_data
);

   generate
      if (LOOKAHEAD) begin : g_look
         logic unused_look;
         assign unused_look = ^{clk, aclr, rd_ok};
         assign rd_data = head;
      end else begin : g_fetch
         logic [DATA_W-1:0] stage1;

         always_ff @(posedge clk or posedge aclr) begin
            if (aclr)       stage1 <= '0;
            else if (rd_ok) stage1 <= head;
         end

         if (OUT_REG) begin : g_oreg
            logic [DATA_W-1:0] stage2;
            always_ff @(posedge clk or posedge aclr) begin
               if (aclr) stage2 <= '0;
               else      stage2 <= stage1;
            end
            assign rd_data = stage2;
         end else begin : g_direct
            assign rd_data = stage1;
         end
      end
   endgenerate

endmodule

// File: rtl/sc_fifo.sv
module sc_fifo #(
   parameter int                    DATA_W    = 8,
   parameter int                    DEPTH     = 16,
   parameter sc_fifo_pkg::rd_mode_e RD_MODE   = sc_fifo_pkg::RD_FETCH,
   parameter bit                    OUT_REG   = 1'b0,
   parameter bit                    OVF_GUARD = 1'b1,
   parameter bit                    UNF_GUARD = 1'b1,
   parameter int                    AF_LEVEL  = 12,
   parameter int                    AE_LEVEL  = 3
) (
   input  logic                     clk,
   input  logic                     aclr,
   input  logic                     sclr,
   input  logic                     wr_en,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     rd_en,
   output logic [DATA_W-1:0]        rd_data,
   output logic [$clog2(DEPTH):0]   count,
   output logic                     full,
   output logic                     empty,
   output logic                     almost_full,
   output logic                     almost_empty,
   output logic                     half_full
);

   localparam int AW        = $clog2(DEPTH);
   localparam bit LOOKAHEAD = (RD_MODE == sc_fifo_pkg::RD_LOOKAHEAD);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sc_fifo: DEPTH must be a power of two and at least 4");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("sc_fifo: DATA_W must be positive");
      end
      if (AF_LEVEL < 1 || AF_LEVEL > DEPTH) begin : g_bad_af
         $error("sc_fifo: AF_LEVEL out of range 1..DEPTH");
      end
      if (AE_LEVEL < 1 || AE_LEVEL > DEPTH) begin : g_bad_ae
         $error("sc_fifo: AE_LEVEL out of range 1..DEPTH");
      end
      if (LOOKAHEAD && OUT_REG) begin : g_bad_oreg
         $error("sc_fifo: OUT_REG is available in fetch mode only");
      end
   endgenerate

   logic                    wr_ok;
   logic                    rd_ok;
   logic [AW-1:0]           wr_ptr;
   logic [AW-1:0]           rd_ptr;
   logic [DATA_W-1:0]       head;
   sc_fifo_pkg::lvl_flags_t flags;

   sc_fifo_ctrl #(
      .DEPTH     (DEPTH),
      .OVF_GUARD (OVF_GUARD),
      .UNF_GUARD (UNF_GUARD),
      .AF_LEVEL  (AF_LEVEL),
      .AE_LEVEL  (AE_LEVEL)
   ) u_ctrl (
      .clk    (clk),
      .aclr   (aclr),
      .sclr   (sclr),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .wr_ok  (wr_ok),
      .rd_ok  (rd_ok),
      .wr_ptr (wr_ptr),
      .rd_ptr (rd_ptr),
      .count  (count),
      .flags  (flags)
   );

   sc_fifo_mem #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_mem (
      .clk   (clk),
      .we    (wr_ok),
      .waddr (wr_ptr),
      .wdata (wr_data),
      .raddr (rd_ptr),
      .rdata (head)
   );

   sc_fifo_rdport #(
      .DATA_W    (DATA_W),
      .LOOKAHEAD (LOOKAHEAD),
      .OUT_REG   (OUT_REG)
   ) u_rdport (
      .clk     (clk),
      .aclr    (aclr),
      .rd_ok   (rd_ok),
      .head    (head),
      .rd_data (rd_data)
   );

   assign full         = flags.full;
   assign empty        = flags.empty;
   assign almost_full  = flags.afull;
   assign almost_empty = flags.aempty;
   assign half_full    = flags.hfull;

endmodule

// File: rtl/sc_fifo_chk.sv
module sc_fifo_chk #(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 16,
   parameter bit LOOKAHEAD = 1'b0,
   parameter bit OUT_REG   = 1'b0,
   parameter bit OVF_GUARD = 1'b1,
   parameter bit UNF_GUARD = 1'b1,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              aclr,
   input logic              sclr,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic [CW-1:0]     count,
   input logic              full,
   input logic              empty
);

   logic seen;
   always_ff @(posedge clk or posedge aclr) begin
      if (aclr) seen <= 1'b0;
      else      seen <= 1'b1;
   end

   // R3: the two end flags never both hold
   a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (aclr)
      !(full && empty));

   // R2: the count moves by at most one word per edge outside a flush
   a_r2_count_step: assert property (@(posedge clk) disable iff (aclr)
      (seen && !$past(sclr)) |->
         (count == $past(count) || count == $past(count) + 1'b1 ||
          count + 1'b1 == $past(count)));

   // R2: a read and a write together in mid range keep the count
   a_r2_rw_balance: assert property (@(posedge clk) disable iff (aclr)
      (seen && $past(wr_en && rd_en && !full && !empty && !sclr)) |->
         (count == $past(count)));

   // R9: a guarded write into a full buffer leaves it full
   a_r9_no_overflow: assert property (@(posedge clk) disable iff (aclr)
      (OVF_GUARD && seen && $past(full && wr_en && !rd_en && !sclr)) |->
         (full && $stable(count)));

   // R10: a guarded read from an empty buffer leaves it empty
   a_r10_no_underflow: assert property (@(posedge clk) disable iff (aclr)
      (UNF_GUARD && seen && $past(empty && rd_en && !wr_en && !sclr)) |->
         empty);

   // R12: an unguarded read on empty does not wrap the count
   a_r12_count_clamp: assert property (@(posedge clk) disable iff (aclr)
      (seen && $past(empty && rd_en && !wr_en && !sclr)) |-> (count == '0));

   // R13: a flush leaves the buffer empty
   a_r13_flush_empties: assert property (@(posedge clk) disable iff (aclr)
      (seen && $past(sclr)) |-> (empty && count == '0));

   // R6: fetch-mode output holds without a read request
   a_r6_hold_data: assert property (@(posedge clk) disable iff (aclr)
      (!LOOKAHEAD && !OUT_REG && seen && $past(!rd_en)) |-> $stable(rd_data));

   // R8: look-ahead head word holds while not acknowledged
   a_r8_head_stable: assert property (@(posedge clk) disable iff (aclr)
      (LOOKAHEAD && seen && $past(!empty && !rd_en && !sclr && !(full && wr_en)))
         |-> $stable(rd_data));

endmodule

bind sc_fifo sc_fifo_chk #(
   .DATA_W    (DATA_W),
   .DEPTH     (DEPTH),
   .LOOKAHEAD (RD_MODE == sc_fifo_pkg::RD_LOOKAHEAD),
   .OUT_REG   (OUT_REG),
   .OVF_GUARD (OVF_GUARD),
   .UNF_GUARD (UNF_GUARD)
) u_chk (
   .clk     (clk),
   .aclr    (aclr),
   .sclr    (sclr),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .rd_data (rd_data),
   .count   (count),
   .full    (full),
   .empty   (empty)
);

// File: tb/tb_sc_fifo.sv
`timescale 1ns/1ps
module tb_sc_fifo;
   import sc_fifo_pkg::*;

   localparam int DW    = 8;
   localparam int DEPTH = 16;
   localparam int AF    = 12;
   localparam int AE    = 3;
   localparam int CW    = $clog2(DEPTH) + 1;

   logic clk = 1'b0;
   logic aclr, sclr, wr_en, rd_en, sa_wr, sa_rd;
   logic [DW-1:0] wr_data;

   logic [DW-1:0] f_q, o_q, s_q;
   logic [CW-1:0] f_cnt, o_cnt, s_cnt;
   logic f_full, f_empty, f_af, f_ae, f_hf;
   logic o_full, o_empty, o_af, o_ae, o_hf;
   logic s_full, s_empty, s_af, s_ae, s_hf;

   always #10 clk = ~clk;

   sc_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .AF_LEVEL(AF), .AE_LEVEL(AE)) dut (
      .clk(clk), .aclr(aclr), .sclr(sclr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(f_q), .count(f_cnt), .full(f_full),
      .empty(f_empty), .almost_full(f_af), .almost_empty(f_ae),
      .half_full(f_hf));

   sc_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .OUT_REG(1'b1),
             .AF_LEVEL(AF), .AE_LEVEL(AE)) dut_or (
      .clk(clk), .aclr(aclr), .sclr(sclr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(o_q), .count(o_cnt), .full(o_full),
      .empty(o_empty), .almost_full(o_af), .almost_empty(o_ae),
      .half_full(o_hf));

   sc_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .RD_MODE(RD_LOOKAHEAD),
             .OVF_GUARD(1'b0), .UNF_GUARD(1'b0),
             .AF_LEVEL(AF), .AE_LEVEL(AE)) dut_sa (
      .clk(clk), .aclr(aclr), .sclr(sclr), .wr_en(sa_wr), .wr_data(wr_data),
      .rd_en(sa_rd), .rd_data(s_q), .count(s_cnt), .full(s_full),
      .empty(s_empty), .almost_full(s_af), .almost_empty(s_ae),
      .half_full(s_hf));

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   logic [DW-1:0] q[$];
   logic [DW-1:0] exp_rd, exp_rd2;
   bit sa_sync;

   task automatic check(input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] b(input bit v);
      return {31'd0, v};
   endfunction

   task automatic check_all();
      int n = q.size();
      check("R2 count", 32'(f_cnt), n);
      check("R3 full", b(f_full), b(n == DEPTH));
      check("R3 empty", b(f_empty), b(n == 0));
      check("R4 almost_full", b(f_af), b(n >= AF));
      check("R4 almost_empty", b(f_ae), b(n < AE));
      check("R5 half_full", b(f_hf), b(n >= DEPTH / 2));
      check("R6 fetch data", 32'(f_q), 32'(exp_rd));
      check("R7 oreg count", 32'(o_cnt), n);
      check("R7 oreg data", 32'(o_q), 32'(exp_rd2));
      if (sa_sync) begin
         check("R8 lookahead count", 32'(s_cnt), n);
         check("R8 lookahead empty", b(s_empty), b(n == 0));
         if (n > 0) check("R8 lookahead head", 32'(s_q), 32'(q[0]));
      end
   endtask

   // Drive at negedge, update the model at the edge, check at next negedge.
   task automatic step(input bit w, input bit r, input bit s,
                       input logic [DW-1:0] d, input bit fw, input bit fr);
      bit wok, rok;
      wr_en = w; rd_en = r; sclr = s; wr_data = d;
      sa_wr = fw | (w && q.size() < DEPTH);
      sa_rd = fr | (r && q.size() > 0);
      @(posedge clk);
      exp_rd2 = exp_rd;
      if (s) begin
         q.delete();
         sa_sync = 1'b1;
      end else begin
         wok = w && q.size() < DEPTH;
         rok = r && q.size() > 0;
         if (rok) exp_rd = q.pop_front();
         if (wok) q.push_back(d);
         if (fw || fr) sa_sync = 1'b0;
      end
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; sclr = 1'b0; sa_wr = 1'b0; sa_rd = 1'b0;
      check_all();
   endtask

   task automatic async_clear();
      #5 aclr = 1'b1;
      #1;
      q.delete(); exp_rd = '0; exp_rd2 = '0; sa_sync = 1'b1;
      check("R1 count", 32'(f_cnt), 0);
      check("R1 empty", b(f_empty), 1);
      check("R1 full", b(f_full), 0);
      check("R1 almost_empty", b(f_ae), 1);
      check("R1 almost_full", b(f_af), 0);
      check("R1 half_full", b(f_hf), 0);
      check("R1 fetch data", 32'(f_q), 0);
      check("R1 oreg data", 32'(o_q), 0);
      check("R1 lookahead count", 32'(s_cnt), 0);
      @(negedge clk);
      aclr = 1'b0;
      @(negedge clk);
      check_all();
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20517));
      aclr = 1'b1; sclr = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      sa_wr = 1'b0; sa_rd = 1'b0; wr_data = '0;
      exp_rd = '0; exp_rd2 = '0; sa_sync = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 count", 32'(f_cnt), 0);
      check("R1 empty", b(f_empty), 1);
      check("R1 almost_empty", b(f_ae), 1);
      check("R1 lookahead empty", b(s_empty), 1);
      aclr = 1'b0;
      @(negedge clk);

      // R2 fill to five, then a balanced read and write
      for (int i = 0; i < 5; i++) step(1, 0, 0, 8'h10 + 8'(i), 0, 0);
      step(1, 1, 0, 8'h15, 0, 0);
      check("R2 balanced rw", 32'(f_cnt), 5);

      // Fill to the top, then a write while full
      for (int i = 0; i < 11; i++) step(1, 0, 0, 8'h20 + 8'(i), 0, 0);
      check("R3 full reached", b(f_full), 1);
      step(1, 0, 0, 8'hA5, 1, 0);
      check("R9 count after dropped write", 32'(f_cnt), DEPTH);
      check("R11 lookahead overwritten head", 32'(s_q), 32'hA5);
      check("R11 lookahead count", 32'(s_cnt), DEPTH);
      check("R11 lookahead full", b(s_full), 1);
      step(0, 1, 0, 8'h00, 0, 0);
      check("R9 oldest word kept", 32'(f_q), 32'h11);
      for (int i = 0; i < 15; i++) step(0, 1, 0, 8'h00, 0, 0);

      // Read while empty
      step(0, 1, 0, 8'h00, 0, 1);
      check("R10 count stays zero", 32'(f_cnt), 0);
      check("R10 data held", 32'(f_q), 32'h2A);
      check("R12 lookahead empty", b(s_empty), 1);
      check("R12 lookahead count", 32'(s_cnt), 0);
      step(0, 0, 1, 8'h00, 0, 0);

      // R13 flush wins over a same-cycle read and write
      for (int i = 0; i < 6; i++) step(1, 0, 0, 8'h40 + 8'(i), 0, 0);
      step(1, 1, 1, 8'h77, 0, 0);
      check("R13 flush count", 32'(f_cnt), 0);
      check("R13 flush lookahead", b(s_empty), 1);
      check("R13 data unchanged", 32'(f_q), 32'h2A);

      // R1 asynchronous clear in mid run
      for (int i = 0; i < 4; i++) step(1, 0, 0, 8'h50 + 8'(i), 0, 0);
      async_clear();

      // Biased random phases: write-heavy, read-heavy, balanced
      for (int ph = 0; ph < 3; ph++) begin
         int wp = (ph == 0) ? 75 : (ph == 1) ? 25 : 50;
         for (int c = 0; c < 600; c++) begin
            bit w = ($urandom % 100) < wp;
            bit r = ($urandom % 100) < (100 - wp);
            bit s = ($urandom % 150) == 0;
            step(w, r, s, 8'($urandom), 0, 0);
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule